// File: doc/BRIEF.md
# Remote DMA Port Engine

This block moves data between a byte-addressed local packet memory and a single host data port. The host first sets a 16-bit start address and a 16-bit byte count, each as a low and a high byte register. It then writes a command code into a three-bit field of the command register. A read command streams memory contents out of the port. A write command takes data from the port and stores it in memory. An abort code stops whatever transfer is running.

Each data-port beat moves one byte, or two bytes when the word mode bit is set. Each beat advances a live address, which the host can read back at any time, and lowers the remaining count. When the count reaches zero, a completion flag rises in the status register. The host clears that flag by writing a one to it.

The memory array lies outside the block. The engine drives the memory's address, write strobe and write data, and it sees the memory's read data combinationally.

Both data directions use valid/ready streams, and a beat happens only on a clock edge where valid and ready are both high:

- **Read direction.** The engine holds `host_rd_valid` high for as long as read bytes remain. It keeps `host_rd_data` and the address steady until the host raises `host_rd_ready`.
- **Write direction.** The engine holds `host_wr_ready` high for as long as write bytes remain. The host may hold back `host_wr_valid` for any number of cycles.

Top module: `rdma_port_engine`

## Requirements

Register offsets: 0x0 command, 0x1/0x2 start address low/high, 0x3/0x4 byte count low/high, 0x5/0x6 current address low/high (read only), 0x7 status, 0x8 mode, 0x9/0xA remaining count low/high (read only).

- R1: After reset:
  - the current address, the remaining count and the status register read zero;
  - `host_rd_valid` and `host_wr_ready` are low.
- R2: A beat takes place only on a clock edge where valid and ready are both high. While the read stream is stalled (valid high, ready low), valid stays high and the address and data do not change.
- R3: A start command copies the programmed start address into the current-address register (offsets 0x5/0x6). Each beat then advances that register.
- R4: The command field is bits 5:3 of offset 0x0:
  - 001 starts a read, which raises `host_rd_valid`;
  - 010 starts a write, which raises `host_wr_ready`.
  The two directions are never active at once.
- R5: Completion flag (bit 6 of offset 0x7):
  - it sets on the clock edge where the remaining count reaches zero;
  - writing 1 to bit 6 clears it;
  - writing 0 to bit 6 leaves it unchanged.
- R6: Once a transfer has completed, the engine accepts no further beats. Valid and ready stay low and the current address holds.
- R7: Word mode (bit 0 of offset 0x8):
  - the count is rounded up to an even number when the transfer starts, and that rounded value is readable at offsets 0x9/0xA;
  - each beat moves two bytes and adds 2 to the address.
- R8: Byte lanes:
  - Word mode, byte-order bit (bit 1 of offset 0x8) clear: data[7:0] is the byte at the current address and data[15:8] is the byte at the next address.
  - Word mode, byte-order bit set: the two bytes are swapped.
  - Byte mode: only data[7:0] carries data, and read data bits 15:8 are zero.
- R9: A command field with bit 5 set (1xx) ends any transfer at once. It does not set the completion flag and it does not change the current address.
- R10: Zero byte count:
  - A register write that leaves the byte count at zero ends a running transfer, without setting the flag.
  - A start command with a zero count loads the address but opens no stream.
- R11: The current address wraps from 0xFFFF to 0x0000.
- R12: The send-packet code 011 does not change the transfer state, the remaining count or the address.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational from `cfg_addr`) |
| host_wr_valid | input | 1 | Host offers a write-direction data beat |
| host_wr_ready | output | 1 | Engine accepts write beats |
| host_wr_data | input | 16 | Write-direction beat data |
| host_rd_valid | output | 1 | Engine offers a read-direction beat |
| host_rd_ready | input | 1 | Host takes the read beat |
| host_rd_data | output | 16 | Read-direction beat data |
| mem_addr | output | 16 | Local memory byte address (the current address) |
| mem_wide | output | 1 | Access covers two bytes (`mem_addr` and `mem_addr`+1) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data, byte at `mem_addr` in bits 7:0 |
| mem_rdata | input | 16 | Memory read data, byte at `mem_addr` in bits 7:0 |

## Verification

The bound checker watches several rules on every cycle:

- a stalled read stream holds its valid and its address;
- the read and write streams are never open together;
- an idle engine stays idle and does not move its address until a register write arrives;
- a word beat adds two to the address, and the remaining count stays even;
- the final beat raises the flag on the next edge;
- an abort, or a count write that leaves zero, closes the stream without touching the flag.

Only the bench scenarios can show the data values themselves: the byte order in both lane modes, the bytes that land in memory on writes, the odd-count rounding seen at the remaining-count registers, address wrap, and write-one-to-clear. They also show that the send code and beats offered after completion leave the engine unchanged.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int unsigned REG_AW = 4;

  // Register offsets
  localparam logic [REG_AW-1:0] OFS_CMD   = 4'h0;
  localparam logic [REG_AW-1:0] OFS_SA_LO = 4'h1;
  localparam logic [REG_AW-1:0] OFS_SA_HI = 4'h2;
  localparam logic [REG_AW-1:0] OFS_BC_LO = 4'h3;
  localparam logic [REG_AW-1:0] OFS_BC_HI = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CA_LO = 4'h5;
  localparam logic [REG_AW-1:0] OFS_CA_HI = 4'h6;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'h7;
  localparam logic [REG_AW-1:0] OFS_MODE  = 4'h8;
  localparam logic [REG_AW-1:0] OFS_RM_LO = 4'h9;
  localparam logic [REG_AW-1:0] OFS_RM_HI = 4'hA;

  // Field positions that the host software decodes
  localparam int unsigned CMD_LSB       = 3;
  localparam int unsigned DONE_BIT      = 6;
  localparam int unsigned MODE_WORD_BIT = 0;
  localparam int unsigned MODE_SWAP_BIT = 1;

  // Command codes; any code with its top bit set aborts, 011 (send) is decoded as no action
  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_mode_e;

endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              word_sel,
  output logic              swap_sel,
  output logic              op_read,
  output logic              op_write,
  output logic              op_abort,
  output logic              cnt_zeroed
);

  localparam int unsigned SA_HI_W = ADDR_W - 8;
  localparam int unsigned BC_HI_W = CNT_W - 8;

  logic [ADDR_W-1:0] sa_nxt;
  logic [CNT_W-1:0]  bc_nxt;
  logic              cmd_hit;
  logic [2:0]        op_field;

  // Next value of the start-address and byte-count registers
  always_comb begin
    sa_nxt = start_addr;
    bc_nxt = byte_cnt;
    if (we) begin
      case (addr)
        OFS_SA_LO: sa_nxt[7:0]        = wdata;
        OFS_SA_HI: sa_nxt[ADDR_W-1:8] = wdata[SA_HI_W-1:0];
        OFS_BC_LO: bc_nxt[7:0]        = wdata;
        OFS_BC_HI: bc_nxt[CNT_W-1:8]  = wdata[BC_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      byte_cnt   <= '0;
      word_sel   <= 1'b0;
      swap_sel   <= 1'b0;
    end else begin
      start_addr <= sa_nxt;
      byte_cnt   <= bc_nxt;
      if (we && addr == OFS_MODE) begin
        word_sel <= wdata[MODE_WORD_BIT];
        swap_sel <= wdata[MODE_SWAP_BIT];
      end
    end
  end

  // Command decode
  assign cmd_hit    = we && (addr == OFS_CMD);
  assign op_field   = wdata[CMD_LSB +: 3];
  assign op_read    = cmd_hit && (op_field == OP_READ);
  assign op_write   = cmd_hit && (op_field == OP_WRITE);
  assign op_abort   = cmd_hit && op_field[2];

  // A count write that leaves the count at zero
  assign cnt_zeroed = we && (addr == OFS_BC_LO || addr == OFS_BC_HI) && (bc_nxt == '0);

endmodule

// File: rtl/rdma_xfer_core.sv
module rdma_xfer_core
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              word_sel,
  input  logic              swap_sel,
  input  logic              op_read,
  input  logic              op_write,
  input  logic              op_abort,
  input  logic              cnt_zeroed,
  input  logic              beat,
  output xfer_mode_e        mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W:0]    rem_cnt,
  output logic              xfer_word,
  output logic              xfer_swap,
  output logic              done_pulse
);

  localparam int unsigned REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] LANE_MASK = REM_W'(BYTES - 1);

  logic [REM_W-1:0] ext_cnt;
  logic [REM_W-1:0] rounded;
  logic [REM_W-1:0] step;
  logic             start_any;
  logic             kill;
  logic             last_beat;

  // Round the count up to a whole number of words when word mode is selected
  assign ext_cnt   = {1'b0, byte_cnt};
  assign rounded   = word_sel ? ((ext_cnt + LANE_MASK) & ~LANE_MASK) : ext_cnt;
  assign step      = xfer_word ? REM_W'(BYTES) : REM_W'(1);
  assign start_any = op_read || op_write;
  assign kill      = op_abort || cnt_zeroed;
  assign last_beat = beat && (rem_cnt <= step);

  // The flag pulses on the same edge that the count reaches zero
  assign done_pulse = last_beat && !kill && !start_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= XF_IDLE;
      cur_addr  <= '0;
      rem_cnt   <= '0;
      xfer_word <= 1'b0;
      xfer_swap <= 1'b0;
    end else if (kill) begin
      mode    <= XF_IDLE;
      rem_cnt <= '0;
    end else if (start_any) begin
      cur_addr  <= start_addr;
      rem_cnt   <= rounded;
      xfer_word <= word_sel;
      xfer_swap <= swap_sel;
      if (rounded == '0)  mode <= XF_IDLE;
      else if (op_read)   mode <= XF_READ;
      else                mode <= XF_WRITE;
    end else if (beat) begin
      cur_addr <= cur_addr + ADDR_W'(step);
      if (last_beat) begin
        rem_cnt <= '0;
        mode    <= XF_IDLE;
      end else begin
        rem_cnt <= rem_cnt - step;
      end
    end
  end

endmodule

// File: rtl/rdma_lane_mux.sv
module rdma_lane_mux #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              word_sel,
  input  logic              swap_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int unsigned BYTES = DATA_W / 8;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam int unsigned MIRROR = BYTES - 1 - g;
    if (g == 0) begin : g_base
      // Lane 0 carries data in byte mode as well
      assign host_rdata[7:0] = (word_sel && swap_sel) ? mem_rdata[MIRROR*8 +: 8]  : mem_rdata[7:0];
      assign mem_wdata[7:0]  = (word_sel && swap_sel) ? host_wdata[MIRROR*8 +: 8] : host_wdata[7:0];
    end else begin : g_upper
      // Upper lanes are used only in word mode
      assign host_rdata[g*8 +: 8] = !word_sel ? 8'h00 :
                                    (swap_sel ? mem_rdata[MIRROR*8 +: 8] : mem_rdata[g*8 +: 8]);
      assign mem_wdata[g*8 +: 8]  = !word_sel ? 8'h00 :
                                    (swap_sel ? host_wdata[MIRROR*8 +: 8] : host_wdata[g*8 +: 8]);
    end
  end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              host_wr_valid,
  output logic              host_wr_ready,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_rd_valid,
  input  logic              host_rd_ready,
  output logic [DATA_W-1:0] host_rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned REM_W = CNT_W + 1;

  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  byte_cnt;
  logic              word_sel, swap_sel;
  logic              op_read, op_write, op_abort, cnt_zeroed;
  xfer_mode_e        mode;
  logic [ADDR_W-1:0] cur_addr;
  logic [REM_W-1:0]  rem_cnt;
  logic              xfer_word, xfer_swap;
  logic              done_pulse;
  logic              done_flag;
  logic              rd_beat, wr_beat, beat;

  rdma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .start_addr (start_addr),
    .byte_cnt   (byte_cnt),
    .word_sel   (word_sel),
    .swap_sel   (swap_sel),
    .op_read    (op_read),
    .op_write   (op_write),
    .op_abort   (op_abort),
    .cnt_zeroed (cnt_zeroed)
  );

  rdma_xfer_core #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTES(BYTES)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .byte_cnt   (byte_cnt),
    .word_sel   (word_sel),
    .swap_sel   (swap_sel),
    .op_read    (op_read),
    .op_write   (op_write),
    .op_abort   (op_abort),
    .cnt_zeroed (cnt_zeroed),
    .beat       (beat),
    .mode       (mode),
    .cur_addr   (cur_addr),
    .rem_cnt    (rem_cnt),
    .xfer_word  (xfer_word),
    .xfer_swap  (xfer_swap),
    .done_pulse (done_pulse)
  );

  rdma_lane_mux #(.DATA_W(DATA_W)) u_lanes (
    .word_sel   (xfer_word),
    .swap_sel   (xfer_swap),
    .mem_rdata  (mem_rdata),
    .host_wdata (host_wr_data),
    .host_rdata (host_rd_data),
    .mem_wdata  (mem_wdata)
  );

  // Stream handshakes
  assign host_rd_valid = (mode == XF_READ);
  assign host_wr_ready = (mode == XF_WRITE);
  assign rd_beat       = host_rd_valid && host_rd_ready;
  assign wr_beat       = host_wr_valid && host_wr_ready;
  assign beat          = rd_beat || wr_beat;

  assign mem_addr = cur_addr;
  assign mem_wide = xfer_word;
  assign mem_we   = wr_beat;

  // Completion flag: setting wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n)
      done_flag <= 1'b0;
    else if (done_pulse)
      done_flag <= 1'b1;
    else if (cfg_we && cfg_addr == OFS_STAT && cfg_wdata[DONE_BIT])
      done_flag <= 1'b0;
  end

  // Register read-back
  always_comb begin
    cfg_rdata = 8'h00;
    case (cfg_addr)
      OFS_SA_LO: cfg_rdata = start_addr[7:0];
      OFS_SA_HI: cfg_rdata = 8'(start_addr >> 8);
      OFS_BC_LO: cfg_rdata = byte_cnt[7:0];
      OFS_BC_HI: cfg_rdata = 8'(byte_cnt >> 8);
      OFS_CA_LO: cfg_rdata = cur_addr[7:0];
      OFS_CA_HI: cfg_rdata = 8'(cur_addr >> 8);
      OFS_STAT:  cfg_rdata[DONE_BIT] = done_flag;
      OFS_MODE: begin
        cfg_rdata[MODE_WORD_BIT] = word_sel;
        cfg_rdata[MODE_SWAP_BIT] = swap_sel;
      end
      OFS_RM_LO: cfg_rdata = rem_cnt[7:0];
      OFS_RM_HI: cfg_rdata = 8'(rem_cnt >> 8);
      default:   cfg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              host_rd_valid,
  input logic              host_rd_ready,
  input logic              host_wr_valid,
  input logic              host_wr_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              xfer_word,
  input logic [CNT_W:0]    rem_cnt,
  input logic [CNT_W-9:0]  bc_hi,
  input logic              done_flag
);

  logic          beat;
  logic [CNT_W:0] step;

  assign beat = (host_rd_valid && host_rd_ready) || (host_wr_valid && host_wr_ready);
  assign step = xfer_word ? (CNT_W+1)'(2) : (CNT_W+1)'(1);

  // R2
  rd_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_valid && !host_rd_ready && !cfg_we) |=> (host_rd_valid && $stable(mem_addr)));

  // R4
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd_valid && host_wr_ready));

  // R5
  flag_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cfg_we && rem_cnt <= step) |=> done_flag);

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd_valid && !host_wr_ready && !cfg_we) |=>
      (!host_rd_valid && !host_wr_ready && $stable(mem_addr)));

  // R7
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && xfer_word && !cfg_we) |=> (mem_addr == ADDR_W'($past(mem_addr) + 2)));

  // R7
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_word && (host_rd_valid || host_wr_ready)) |-> !rem_cnt[0]);

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CMD && cfg_wdata[CMD_LSB+2]) |=>
      (!host_rd_valid && !host_wr_ready && done_flag == $past(done_flag)));

  // R10
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_BC_LO && cfg_wdata == 8'h00 && bc_hi == '0) |=>
      (!host_rd_valid && !host_wr_ready && done_flag == $past(done_flag)));

endmodule

bind rdma_port_engine rdma_port_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .cfg_wdata     (cfg_wdata),
  .host_rd_valid (host_rd_valid),
  .host_rd_ready (host_rd_ready),
  .host_wr_valid (host_wr_valid),
  .host_wr_ready (host_wr_ready),
  .mem_addr      (mem_addr),
  .xfer_word     (xfer_word),
  .rem_cnt       (rem_cnt),
  .bc_hi         (byte_cnt[CNT_W-1:8]),
  .done_flag     (done_flag)
);

// File: tb/test_rdma_port_engine.sv
`timescale 1ns/1ps
module test_rdma_port_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        host_wr_valid = 1'b0;
  logic        host_wr_ready;
  logic [15:0] host_wr_data = '0;
  logic        host_rd_valid;
  logic        host_rd_ready = 1'b0;
  logic [15:0] host_rd_data;
  logic [15:0] mem_addr;
  logic        mem_wide, mem_we;
  logic [15:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string cur_tag = "";

  always #2 clk = ~clk;

  rdma_port_engine i_rdma_port_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
    .host_wr_data(host_wr_data), .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready),
    .host_rd_data(host_rd_data), .mem_addr(mem_addr), .mem_wide(mem_wide), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Local memory model, 256 bytes aliased over the address space
  logic [7:0] mem [0:255];
  assign mem_rdata = {mem[8'(mem_addr + 16'd1)], mem[mem_addr[7:0]]};
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_wide) mem[8'(mem_addr + 16'd1)] <= mem_wdata[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    reg_rd(lo, l);
    reg_rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic setup(input logic [15:0] sa, input logic [15:0] bc, input logic word, input logic swap);
    reg_wr(4'h8, {6'b0, swap, word});
    reg_wr(4'h1, sa[7:0]);
    reg_wr(4'h2, sa[15:8]);
    reg_wr(4'h3, bc[7:0]);
    reg_wr(4'h4, bc[15:8]);
  endtask

  // Expected beat value from the requirement's lane rules (R8)
  function automatic logic [15:0] exp_val(input logic [15:0] a, input logic word, input logic swap);
    logic [7:0] b0, b1;
    b0 = mem[a[7:0]];
    b1 = mem[8'(a + 16'd1)];
    if (!word) return {8'h00, b0};
    return swap ? {b0, b1} : {b1, b0};
  endfunction

  // Driver side of the scoreboard: push expected read beats
  task automatic queue_reads(input logic [15:0] sa, input int n, input logic word, input logic swap);
    for (int i = 0; i < n; i++)
      exp_q.push_back(exp_val(16'(sa + i * (word ? 2 : 1)), word, swap));
  endtask

  task automatic rd_beats(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_rd_ready = 1'b1;
    end
    @(negedge clk);
    host_rd_ready = 1'b0;
  endtask

  task automatic wr_beats(input logic [15:0] vals [4], input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_wr_valid = 1'b1;
      host_wr_data  = vals[i];
    end
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && host_rd_valid && host_rd_ready) begin
      if (exp_q.size() == 0) chk({cur_tag, " unexpected beat"}, 32'(host_rd_data), 32'hFFFF_FFFF);
      else chk(cur_tag, 32'(host_rd_data), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  r8;
    logic [15:0] r16;
    logic [15:0] wv [4];
    logic [7:0]  keep;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd16(4'h5, r16); chk("R1 cur addr", 32'(r16), 0);
    rd16(4'h9, r16); chk("R1 remaining", 32'(r16), 0);
    reg_rd(4'h7, r8); chk("R1 status", 32'(r8), 0);
    chk("R1 rd_valid", 32'(host_rd_valid), 0);
    chk("R1 wr_ready", 32'(host_wr_ready), 0);

    // R4 R3: byte read of 5
    cur_tag = "R4 byte read data";
    setup(16'h0010, 16'd5, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h08);
    rd16(4'h5, r16); chk("R3 address loaded", 32'(r16), 32'h10);
    chk("R4 rd_valid open", 32'(host_rd_valid), 1);
    chk("R4 wr_ready closed", 32'(host_wr_ready), 0);
    queue_reads(16'h0010, 5, 1'b0, 1'b0);
    rd_beats(2);
    rd16(4'h5, r16); chk("R3 address advanced", 32'(r16), 32'h12);
    rd_beats(2);
    rd16(4'h9, r16); chk("R5 remaining one", 32'(r16), 1);
    reg_rd(4'h7, r8); chk("R5 flag not early", 32'(r8), 0);
    rd_beats(1);
    reg_rd(4'h7, r8); chk("R5 flag at zero", 32'(r8), 32'h40);
    rd16(4'h9, r16); chk("R5 remaining zero", 32'(r16), 0);
    rd16(4'h5, r16); chk("R3 end address", 32'(r16), 32'h15);
    // R6: beats after completion are ignored
    rd_beats(2);
    chk("R6 no valid after done", 32'(host_rd_valid), 0);
    rd16(4'h5, r16); chk("R6 address held", 32'(r16), 32'h15);
    chk("R4 all beats seen", 32'(exp_q.size()), 0);

    // R5: write-one-to-clear
    reg_wr(4'h7, 8'h00);
    reg_rd(4'h7, r8); chk("R5 write 0 keeps", 32'(r8), 32'h40);
    reg_wr(4'h7, 8'hBF);
    reg_rd(4'h7, r8); chk("R5 other bits keep", 32'(r8), 32'h40);
    reg_wr(4'h7, 8'h40);
    reg_rd(4'h7, r8); chk("R5 write 1 clears", 32'(r8), 0);

    // R7 R8 R2: word read, odd count, odd start, no swap, with stall
    cur_tag = "R8 word read no swap";
    setup(16'h0021, 16'd5, 1'b1, 1'b0);
    reg_wr(4'h0, 8'h08);
    rd16(4'h9, r16); chk("R7 count rounded", 32'(r16), 6);
    queue_reads(16'h0021, 3, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk("R2 valid held in stall", 32'(host_rd_valid), 1);
    chk("R2 data held in stall", 32'(host_rd_data), 32'(exp_val(16'h0021, 1'b1, 1'b0)));
    rd16(4'h5, r16); chk("R2 address held in stall", 32'(r16), 32'h21);
    rd_beats(3);
    rd16(4'h5, r16); chk("R7 address by two", 32'(r16), 32'h27);
    reg_rd(4'h7, r8); chk("R7 word done", 32'(r8), 32'h40);
    chk("R7 beats seen", 32'(exp_q.size()), 0);
    reg_wr(4'h7, 8'h40);

    // R8: word read swapped
    cur_tag = "R8 word read swap";
    setup(16'h0030, 16'd4, 1'b1, 1'b1);
    reg_wr(4'h0, 8'h08);
    queue_reads(16'h0030, 2, 1'b1, 1'b1);
    rd_beats(2);
    chk("R8 swap beats seen", 32'(exp_q.size()), 0);
    reg_wr(4'h7, 8'h40);

    // R4: byte write of 3
    setup(16'h0040, 16'd3, 1'b0, 1'b0);
    keep = mem[8'h43];
    reg_wr(4'h0, 8'h10);
    chk("R4 wr_ready open", 32'(host_wr_ready), 1);
    chk("R4 rd_valid closed", 32'(host_rd_valid), 0);
    wv = '{16'hFFA1, 16'h00B2, 16'h55C3, 16'h0};
    wr_beats(wv, 3);
    @(negedge clk);
    chk("R4 write byte 0", 32'(mem[8'h40]), 32'hA1);
    chk("R4 write byte 1", 32'(mem[8'h41]), 32'hB2);
    chk("R4 write byte 2", 32'(mem[8'h42]), 32'hC3);
    chk("R6 byte past end untouched", 32'(mem[8'h43]), 32'(keep));
    reg_rd(4'h7, r8); chk("R5 write done", 32'(r8), 32'h40);
    reg_wr(4'h7, 8'h40);

    // R8 R7: word write swapped, count 3 -> 4
    setup(16'h0050, 16'd3, 1'b1, 1'b1);
    keep = mem[8'h54];
    reg_wr(4'h0, 8'h10);
    wv = '{16'h1234, 16'h5678, 16'h0, 16'h0};
    wr_beats(wv, 2);
    @(negedge clk);
    chk("R8 swapped write 0", 32'(mem[8'h50]), 32'h12);
    chk("R8 swapped write 1", 32'(mem[8'h51]), 32'h34);
    chk("R8 swapped write 2", 32'(mem[8'h52]), 32'h56);
    chk("R7 rounded write 3", 32'(mem[8'h53]), 32'h78);
    chk("R7 no extra byte", 32'(mem[8'h54]), 32'(keep));
    chk("R6 wr_ready closed", 32'(host_wr_ready), 0);
    reg_wr(4'h7, 8'h40);

    // R9: abort mid-transfer
    cur_tag = "R9 read before abort";
    setup(16'h0060, 16'd10, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h08);
    queue_reads(16'h0060, 2, 1'b0, 1'b0);
    rd_beats(2);
    reg_wr(4'h0, 8'h20);
    #1 chk("R9 valid dropped", 32'(host_rd_valid), 0);
    reg_rd(4'h7, r8); chk("R9 no flag", 32'(r8), 0);
    rd16(4'h5, r16); chk("R9 address kept", 32'(r16), 32'h62);

    // R10: count write to zero ends a write
    setup(16'h0070, 16'd10, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h10);
    wv = '{16'h005A, 16'h0, 16'h0, 16'h0};
    wr_beats(wv, 1);
    reg_wr(4'h3, 8'h00);
    #1 chk("R10 ready dropped", 32'(host_wr_ready), 0);
    reg_rd(4'h7, r8); chk("R10 no flag", 32'(r8), 0);
    rd16(4'h5, r16); chk("R10 address kept", 32'(r16), 32'h71);
    chk("R10 first byte stored", 32'(mem[8'h70]), 32'h5A);
    // R10: start with zero count
    setup(16'h0080, 16'd0, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h08);
    #1 chk("R10 zero start no valid", 32'(host_rd_valid), 0);
    rd16(4'h5, r16); chk("R10 zero start address", 32'(r16), 32'h80);
    reg_rd(4'h7, r8); chk("R10 zero start no flag", 32'(r8), 0);

    // R11: wrap
    cur_tag = "R11 wrap read";
    setup(16'hFFFE, 16'd3, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h08);
    queue_reads(16'hFFFE, 3, 1'b0, 1'b0);
    rd_beats(3);
    rd16(4'h5, r16); chk("R11 byte wrap", 32'(r16), 32'h0001);
    reg_wr(4'h7, 8'h40);
    setup(16'hFFFE, 16'd2, 1'b1, 1'b0);
    reg_wr(4'h0, 8'h08);
    queue_reads(16'hFFFE, 1, 1'b1, 1'b0);
    rd_beats(1);
    rd16(4'h5, r16); chk("R11 word wrap", 32'(r16), 32'h0000);
    reg_wr(4'h7, 8'h40);

    // R12: send code has no effect
    reg_wr(4'h0, 8'h18);
    #1 chk("R12 idle no valid", 32'(host_rd_valid), 0);
    chk("R12 idle no ready", 32'(host_wr_ready), 0);
    rd16(4'h5, r16); chk("R12 idle address", 32'(r16), 0);
    cur_tag = "R12 read around send";
    setup(16'h0090, 16'd4, 1'b0, 1'b0);
    reg_wr(4'h0, 8'h08);
    queue_reads(16'h0090, 1, 1'b0, 1'b0);
    rd_beats(1);
    reg_wr(4'h0, 8'h18);
    rd16(4'h9, r16); chk("R12 remaining kept", 32'(r16), 3);
    rd16(4'h5, r16); chk("R12 address kept", 32'(r16), 32'h91);
    chk("R12 still valid", 32'(host_rd_valid), 1);
    reg_wr(4'h0, 8'h20);
    chk("R12 queue drained", 32'(exp_q.size()), 0);

    summary();
  end

endmodule